// File: doc/BRIEF.md
# Passive LCD Line Scan Controller

This block drives a passive-matrix LCD panel of up to sub-VGA size from a byte-wide line buffer. It fetches the bytes of one display line in ascending address order, slices each byte into pixel groups of the selected bus width, and shifts them out on a pixel bus. Alongside the data it produces a pixel clock, a one-period line latch after the last pixel of each line, a frame sync that marks the first line, a polarization output that alternates once per frame, and a display-enable output.

Bus width, pixel clock active edge, latch polarity, bytes per line and lines per frame are run-time inputs. They are meant to be set while the display is off. While the display is off the pixel bus and pixel clock rest. Turning the display on again restarts the scan at line 0, byte 0. One pixel-clock period lasts two system clocks. The line buffer is a synchronous read port with one cycle of latency.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: `cfg_width` selects the pixel bus width: 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 8 bits. Each byte is sent in 8/width pixel periods, most significant group first. The group sits in the low bits of `lcd_pix` and the unused upper bits are 0.
- R2: In each line, bytes are read from line buffer addresses 0, 1, … `cfg_bytes`-1 in that order, with exactly one read per byte. The data appears on `lb_data` one clock after `lb_rd_en`.
- R3: After the last group of a line's last byte, the line latch is active for exactly one pixel period, and at no other time. The active level is high when `cfg_latch_low`=0 and low when it is 1. `lcd_pix` is 0 during the latch period.
- R4: A pixel period is two clocks. `lcd_pix` changes only while `lcd_cp` is at its resting level, which is the value of `cfg_cp_fall`. The active edge comes mid-period: rising when `cfg_cp_fall`=0 and falling when it is 1.
- R5: `lcd_fsync` is high during every pixel period of line 0, its latch period included, and low during all other lines.
- R6: `lcd_pol` toggles once per frame, at the start of the latch period that ends line `cfg_lines`-1. The frame length is `cfg_lines` lines, from 1 to MAX_LINES. `lcd_pol` holds its value while the display is off.
- R7: `lcd_disp` is high while the display is on and low while it is off, following `cfg_enable` one clock later.
- R8: While `cfg_enable` is 0, the outputs rest: `lcd_pix` is 0, `lcd_cp` is at its resting level, the latch is inactive, `lcd_fsync` is 0 and no reads are made. Enabling again starts at line 0, byte 0, group 0.
- R9: After reset, with the display off, `lcd_pix`, `lcd_cp`, `lcd_fsync`, `lcd_pol`, `lcd_disp` and `lb_rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Display on (1) / off (0) |
| cfg_width | input | 2 | Pixel bus width code |
| cfg_cp_fall | input | 1 | 1: falling active edge of the pixel clock |
| cfg_latch_low | input | 1 | 1: line latch active low |
| cfg_bytes | input | $clog2(MAX_BYTES+1) | Bytes per line, 1..MAX_BYTES |
| cfg_lines | input | $clog2(MAX_LINES+1) | Lines per frame, 1..MAX_LINES |
| lb_rd_en | output | 1 | Line buffer read strobe |
| lb_addr | output | $clog2(MAX_BYTES) | Line buffer byte address |
| lb_data | input | 8 | Line buffer read data, one clock after the strobe |
| lcd_pix | output | 8 | Pixel data bus |
| lcd_cp | output | 1 | Pixel clock |
| lcd_latch | output | 1 | Line latch |
| lcd_fsync | output | 1 | First-line frame sync |
| lcd_pol | output | 1 | Alternating polarization |
| lcd_disp | output | 1 | Display enable |

## Verification
The bench builds the block with MAX_BYTES=4 and MAX_LINES=6. This puts the full byte-count range 1..4 and a frame-length range that includes a one-line frame and the maximum frame within a short run. It sweeps all 16 combinations of width, clock edge and latch polarity, and crosses each with a varied line length and frame length. Each run covers two frames and stops mid-line, so every later run also exercises the restart after the display is turned off. With one-line frames, the frame sync stays high and the polarization toggles on every latch, which checks that these two corner cases track the frame count.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef enum logic [1:0] {
      PW_1 = 2'd0,
      PW_2 = 2'd1,
      PW_4 = 2'd2,
      PW_8 = 2'd3
   } pix_width_e;

   typedef enum logic {
      SEQ_SHIFT = 1'b0,
      SEQ_LATCH = 1'b1
   } seq_mode_e;

   // index of the final pixel group inside one byte for a given width
   function automatic logic [2:0] final_group(pix_width_e w);
      logic [3:0] groups;
      groups = 4'd8 >> w;
      return 3'(groups - 4'd1);
   endfunction

endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic cp_fall,
   output logic phase_o,
   output logic boundary_o,
   output logic cp_o
);

   logic live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_o <= 1'b0;
         live_q  <= 1'b0;
         cp_o    <= 1'b0;
      end else if (!en) begin
         phase_o <= 1'b0;
         live_q  <= 1'b0;
         cp_o    <= cp_fall;
      end else begin
         phase_o <= ~phase_o;
         if (phase_o) begin
            live_q <= 1'b1;
            cp_o   <= cp_fall;
         end else begin
            cp_o   <= live_q ? ~cp_fall : cp_fall;
         end
      end
   end

   assign boundary_o = en & phase_o;

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
   import lcd_scan_pkg::*;
#(
   parameter int MAX_BYTES = 80,
   parameter int MAX_LINES = 640,
   localparam int ADDR_W  = $clog2(MAX_BYTES),
   localparam int BCFG_W  = $clog2(MAX_BYTES + 1),
   localparam int LINE_W  = $clog2(MAX_LINES),
   localparam int LCFG_W  = $clog2(MAX_LINES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              phase,
   input  logic              boundary,
   input  pix_width_e        width,
   input  logic [BCFG_W-1:0] bytes_per_line,
   input  logic [LCFG_W-1:0] lines_per_frame,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              shift_o,
   output logic              load_o,
   output logic [2:0]        group_o,
   output logic              latch_act_o,
   output logic              fsync_o,
   output logic              pol_o
);

   seq_mode_e         mode_q;
   logic [ADDR_W-1:0] byte_q;
   logic [2:0]        grp_q;
   logic [LINE_W-1:0] line_q;
   logic              last_grp, last_byte, last_line;

   assign last_grp  = (grp_q == final_group(width));
   assign last_byte = (byte_q == ADDR_W'(bytes_per_line - 1'b1));
   assign last_line = (line_q == LINE_W'(lines_per_frame - 1'b1));

   // counters describe the period about to be launched at the next boundary
   assign rd_en_o   = en && !phase && (mode_q == SEQ_SHIFT) && (grp_q == 3'd0);
   assign rd_addr_o = byte_q;
   assign shift_o   = boundary && (mode_q == SEQ_SHIFT);
   assign load_o    = (grp_q == 3'd0);
   assign group_o   = grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= SEQ_SHIFT;
         byte_q      <= '0;
         grp_q       <= '0;
         line_q      <= '0;
         latch_act_o <= 1'b0;
         fsync_o     <= 1'b0;
         pol_o       <= 1'b0;
      end else if (!en) begin
         mode_q      <= SEQ_SHIFT;
         byte_q      <= '0;
         grp_q       <= '0;
         line_q      <= '0;
         latch_act_o <= 1'b0;
         fsync_o     <= 1'b0;
      end else if (boundary) begin
         latch_act_o <= (mode_q == SEQ_LATCH);
         fsync_o     <= (line_q == '0);
         if (mode_q == SEQ_LATCH) begin
            mode_q <= SEQ_SHIFT;
            line_q <= last_line ? '0 : line_q + 1'b1;
            if (last_line) pol_o <= ~pol_o;
         end else if (last_grp) begin
            grp_q <= '0;
            if (last_byte) begin
               byte_q <= '0;
               mode_q <= SEQ_LATCH;
            end else begin
               byte_q <= byte_q + 1'b1;
            end
         end else begin
            grp_q <= grp_q + 1'b1;
         end
      end
   end

   // R2: no read beyond the programmed line length
   a_r2_addr_in_line: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |-> (BCFG_W'(rd_addr_o) < bytes_per_line));

   // R3: latch lasts one pixel period (two clocks), never more
   a_r3_latch_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_act_o) |=> latch_act_o);
   a_r3_latch_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_act_o && $past(latch_act_o)) |=> !latch_act_o);

   // R6: polarization only moves together with a latch period
   a_r6_pol_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pol_o) |-> latch_act_o);

endmodule

// File: rtl/lcd_scan_shift.sv
module lcd_scan_shift
   import lcd_scan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       boundary,
   input  logic       shift,
   input  logic       load,
   input  logic [2:0] group,
   input  pix_width_e width,
   input  logic [7:0] lb_data,
   output logic [7:0] pix_o
);

   logic [7:0] hold_q;
   logic [7:0] src;
   logic [7:0] grp_val [4];

   assign src = load ? lb_data : hold_q;

   // one extractor per supported width, most significant group first
   for (genvar gi = 0; gi < 4; gi++) begin : g_width
      localparam int W = 1 << gi;
      logic [7:0] aligned;
      assign aligned     = src << (group * 3'(W));
      assign grp_val[gi] = 8'(aligned[7 -: W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         pix_o  <= '0;
      end else if (!en) begin
         pix_o  <= '0;
      end else if (shift) begin
         if (load) hold_q <= lb_data;
         pix_o <= grp_val[width];
      end else if (boundary) begin
         pix_o <= '0;
      end
   end

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
   import lcd_scan_pkg::*;
#(
   parameter int MAX_BYTES = 80,
   parameter int MAX_LINES = 640,
   localparam int ADDR_W  = $clog2(MAX_BYTES),
   localparam int BCFG_W  = $clog2(MAX_BYTES + 1),
   localparam int LCFG_W  = $clog2(MAX_LINES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_width,
   input  logic              cfg_cp_fall,
   input  logic              cfg_latch_low,
   input  logic [BCFG_W-1:0] cfg_bytes,
   input  logic [LCFG_W-1:0] cfg_lines,
   output logic              lb_rd_en,
   output logic [ADDR_W-1:0] lb_addr,
   input  logic [7:0]        lb_data,
   output logic [7:0]        lcd_pix,
   output logic              lcd_cp,
   output logic              lcd_latch,
   output logic              lcd_fsync,
   output logic              lcd_pol,
   output logic              lcd_disp
);

   if (MAX_BYTES < 2) begin : g_bad_bytes
      $error("MAX_BYTES must be at least 2");
   end
   if (MAX_LINES < 2) begin : g_bad_lines
      $error("MAX_LINES must be at least 2");
   end

   pix_width_e width;
   logic       phase, boundary, shift, load, latch_act;
   logic [2:0] group;

   assign width = pix_width_e'(cfg_width);

   lcd_scan_timing u_timing (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cfg_enable),
      .cp_fall    (cfg_cp_fall),
      .phase_o    (phase),
      .boundary_o (boundary),
      .cp_o       (lcd_cp)
   );

   lcd_scan_seq #(
      .MAX_BYTES (MAX_BYTES),
      .MAX_LINES (MAX_LINES)
   ) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .en              (cfg_enable),
      .phase           (phase),
      .boundary        (boundary),
      .width           (width),
      .bytes_per_line  (cfg_bytes),
      .lines_per_frame (cfg_lines),
      .rd_en_o         (lb_rd_en),
      .rd_addr_o       (lb_addr),
      .shift_o         (shift),
      .load_o          (load),
      .group_o         (group),
      .latch_act_o     (latch_act),
      .fsync_o         (lcd_fsync),
      .pol_o           (lcd_pol)
   );

   lcd_scan_shift u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_enable),
      .boundary (boundary),
      .shift    (shift),
      .load     (load),
      .group    (group),
      .width    (width),
      .lb_data  (lb_data),
      .pix_o    (lcd_pix)
   );

   assign lcd_latch = latch_act ^ cfg_latch_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lcd_disp <= 1'b0;
      else        lcd_disp <= cfg_enable;
   end

   // R4: pixel data only moves while the pixel clock rests
   a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lcd_pix) |-> (lcd_cp == cfg_cp_fall));

   // R8: display off forces the LCD pins to rest
   a_r8_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (lcd_pix == 8'd0 && !lcd_fsync && !lcd_disp));

endmodule

// File: tb/lcd_scan_ctrl_tb_top.sv
module lcd_scan_ctrl_tb_top;

   localparam int MB = 4;
   localparam int ML = 6;
   localparam int AW = $clog2(MB);
   localparam int BW = $clog2(MB + 1);
   localparam int LW = $clog2(ML + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_enable = 1'b0;
   logic [1:0]    cfg_width = 2'd0;
   logic          cfg_cp_fall = 1'b0;
   logic          cfg_latch_low = 1'b0;
   logic [BW-1:0] cfg_bytes = BW'(1);
   logic [LW-1:0] cfg_lines = LW'(1);
   logic          lb_rd_en;
   logic [AW-1:0] lb_addr;
   logic [7:0]    lb_data = 8'd0;
   logic [7:0]    lcd_pix;
   logic          lcd_cp, lcd_latch, lcd_fsync, lcd_pol, lcd_disp;

   always #5 clk = ~clk;

   lcd_scan_ctrl #(.MAX_BYTES(MB), .MAX_LINES(ML)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_width(cfg_width),
      .cfg_cp_fall(cfg_cp_fall), .cfg_latch_low(cfg_latch_low),
      .cfg_bytes(cfg_bytes), .cfg_lines(cfg_lines),
      .lb_rd_en(lb_rd_en), .lb_addr(lb_addr), .lb_data(lb_data),
      .lcd_pix(lcd_pix), .lcd_cp(lcd_cp), .lcd_latch(lcd_latch),
      .lcd_fsync(lcd_fsync), .lcd_pol(lcd_pol), .lcd_disp(lcd_disp)
   );

   function automatic logic [7:0] pattern(int a);
      return 8'((a * 37 + 8'h5A) & 8'hFF);
   endfunction

   // line buffer model: one clock read latency
   always @(posedge clk) if (lb_rd_en) lb_data <= pattern(int'(lb_addr));

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scan expectation state
   bit mon_on = 0, first_edge = 1, elatch = 0, exp_pol = 0, prev_cp = 0;
   int eb = 0, eg = 0, el = 0, exp_rd = 0, gap = 0, nsamp = 0;
   int w_code = 0, nbytes = 1, nlines = 1;
   logic [7:0] prev_pix = 8'd0;

   always @(negedge clk) begin
      gap++;
      if (mon_on) begin
         if (lb_rd_en) begin
            chk(int'(lb_addr) == exp_rd, "R2 read address", int'(lb_addr), exp_rd);
            exp_rd = (exp_rd + 1) % nbytes;
         end
         if (lcd_pix != prev_pix)
            chk(lcd_cp == cfg_cp_fall, "R4 data moved with clock active", lcd_cp, cfg_cp_fall);
         if (lcd_cp != prev_cp && lcd_cp != cfg_cp_fall) begin
            int gw, gn, ev;
            gw = 1 << w_code;
            gn = 8 >> w_code;
            if (!first_edge) chk(gap == 2, "R4 pixel period", gap, 2);
            first_edge = 0;
            gap = 0;
            chk(lcd_fsync == (el == 0), "R5 frame sync", lcd_fsync, el == 0);
            chk(lcd_disp == 1'b1, "R7 display enable on", lcd_disp, 1);
            if (!elatch) begin
               ev = (int'(pattern(eb)) >> (8 - gw * (eg + 1))) & ((1 << gw) - 1);
               chk(int'(lcd_pix) == ev, "R1 pixel group", lcd_pix, ev);
               chk(lcd_latch == cfg_latch_low, "R3 latch inactive", lcd_latch, cfg_latch_low);
               eg++;
               if (eg == gn) begin
                  eg = 0;
                  eb++;
                  if (eb == nbytes) begin eb = 0; elatch = 1; end
               end
            end else begin
               chk(lcd_latch == !cfg_latch_low, "R3 latch active", lcd_latch, !cfg_latch_low);
               chk(lcd_pix == 8'd0, "R3 pixel zero in latch", lcd_pix, 0);
               if (el == nlines - 1) exp_pol = ~exp_pol;
               el = (el + 1) % nlines;
               elatch = 0;
            end
            chk(lcd_pol == exp_pol, "R6 polarization", lcd_pol, exp_pol);
            nsamp++;
         end
      end
      prev_pix = lcd_pix;
      prev_cp  = lcd_cp;
   end

   task automatic run_cfg(input int wc, input bit fall, input bit low,
                          input int nb, input int nl);
      int target;
      @(posedge clk); #1;
      cfg_enable = 0;
      mon_on = 0;
      repeat (2) @(posedge clk);
      #1;
      cfg_width = 2'(wc); cfg_cp_fall = fall; cfg_latch_low = low;
      cfg_bytes = BW'(nb); cfg_lines = LW'(nl);
      w_code = wc; nbytes = nb; nlines = nl;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(lcd_pix == 8'd0 && lcd_cp == fall, "R8 idle pix/clock", {lcd_pix, lcd_cp}, {8'd0, fall});
      chk(lcd_latch == low && !lcd_fsync && !lb_rd_en, "R8 idle latch/sync/read",
          {lcd_latch, lcd_fsync, lb_rd_en}, {low, 2'b00});
      chk(lcd_disp == 1'b0, "R7 display enable off", lcd_disp, 0);
      eb = 0; eg = 0; el = 0; elatch = 0; exp_rd = 0; first_edge = 1; nsamp = 0;
      @(posedge clk); #1;
      cfg_enable = 1;
      mon_on = 1;
      target = 2 * nl * (nb * (8 >> wc) + 1) + 3;
      while (nsamp < target) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(lcd_pix == 8'd0 && !lcd_cp && !lcd_fsync, "R9 reset pix/clock/sync",
          {lcd_pix, lcd_cp, lcd_fsync}, 0);
      chk(!lcd_pol && !lcd_disp && !lb_rd_en && !lcd_latch, "R9 reset pol/disp/read",
          {lcd_pol, lcd_disp, lb_rd_en, lcd_latch}, 0);
      for (int i = 0; i < 16; i++) begin
         int lines_tab [3] = '{1, 2, ML};
         run_cfg(i % 4, (i / 4) % 2, (i / 8) % 2, (i % MB) + 1, lines_tab[i % 3]);
      end
      // extra: longest line and frame at full width
      run_cfg(3, 0, 1, MB, ML);
      run_cfg(0, 1, 0, MB, ML);
      @(posedge clk); #1 cfg_enable = 0; mon_on = 0;
      repeat (3) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule